// File: doc/BRIEF.md
# Grouped Interrupt Status Encoder with DMA Cascade

This block collects interrupt requests from three source groups and presents them to software as one encoded status word. The groups are a small critical group, a main group and a peripheral group. For each group the word carries a valid flag and the number of the lowest-numbered pending source that is not masked. Software reads the critical field first, then the main field, then the peripheral field.

Peripheral source 0 has no request pin of its own. It stands for a second-level bank of DMA task interrupts. Each task pulse sets a sticky pending bit, and each task has its own mask bit. Peripheral source 0 is pending while any unmasked DMA pending bit is set. Software clears pending bits by writing ones to them. The masks and the DMA bank sit behind a small register port. A single CPU interrupt line is raised while any group has a valid source.

The block has no streaming data path. All pins are plain level control and status signals with no handshake. The request vectors are sampled into registers on each clock, so any change shows in the status word one cycle later.

Top module: `irq_status_encoder`

## Requirements
- R1: After reset the status word reads 0 and the CPU interrupt is low. Register address 0 (main mask) reads 0x00010fff, address 1 (peripheral mask) reads 0x7ffffc00, address 2 (DMA pending) reads 0 and address 3 (DMA mask) reads 0xffffffff.
- R2: Status bit 10 is set one cycle after any critical request is high. Bits [9:8] then hold the number of the lowest-numbered such request. Critical sources have no mask.
- R3: Status bit 21 flags a pending main source and bits [20:16] hold the lowest-numbered unmasked one. Main source n (n < 16) is disabled by main mask bit 15-n, and source 16 is disabled by bit 16. A mask bit of 1 disables the source.
- R4: Status bit 29 flags a pending peripheral source and bits [28:24] hold the lowest-numbered unmasked one. Peripheral source n is disabled by peripheral mask bit 31-n when that bit is 1.
- R5: Peripheral source 0 is pending when the DMA pending bits ANDed with the inverse of the DMA mask are nonzero. DMA mask bit n set to 1 disables task n. Peripheral mask bit 31 gates this cascade.
- R6: A pulse on DMA task input n sets DMA pending bit n, and the bit stays set. Writing 1 to bit n at address 2 clears it. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R7: Each group's number field reads 0 while that group's valid flag is clear. All status bits outside the three fields and flags read 0.
- R8: The CPU interrupt output is high exactly when at least one of the three valid flags is set.
- R9: The three groups are encoded independently and all at once. Critical code 2 and main code 4 are reported as ordinary numbers, and the peripheral field is still filled in alongside them for the reader to follow.
- R10: A write at address 0, 1 or 3 replaces the whole register and takes effect from the next cycle. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 4 | Critical source requests |
| main_req | input | 17 | Main source requests |
| per_req | input | 31 | Peripheral source requests 1..31 (index 0 is the DMA cascade) |
| dma_evt | input | 32 | DMA task interrupt pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 main mask, 1 peripheral mask, 2 DMA pending, 3 DMA mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| status_word | output | 32 | Encoded group status |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
Single requests in each group show that the number field and the one-cycle latency are correct. Several requests at once show that the lowest-numbered one wins. Requests on masked and unmasked positions show the reversed mask bit order, which a design with direct bit order would get wrong. The DMA tests use masked and unmasked tasks, write-one clears and a clear in the same cycle as a set, which separates the sticky, masking and set-wins rules. A long random run with register writes mixed in is compared every cycle against a behavioural model.

// File: rtl/irqe_pkg.sv
package irqe_pkg;
  localparam int REG_W     = 32;
  localparam int CRIT_FLAG = 10;
  localparam int CRIT_LSB  = 8;
  localparam int MAIN_FLAG = 21;
  localparam int MAIN_LSB  = 16;
  localparam int PER_FLAG  = 29;
  localparam int PER_LSB   = 24;

  localparam logic [REG_W-1:0] MAIN_MASK_INIT = 32'h0001_0fff;
  localparam logic [REG_W-1:0] PER_MASK_INIT  = 32'h7fff_fc00;

  typedef enum logic [1:0] {
    RA_MAIN_MASK = 2'd0,
    RA_PER_MASK  = 2'd1,
    RA_DMA_PEND  = 2'd2,
    RA_DMA_MASK  = 2'd3
  } reg_addr_e;

  // mask bit that disables main source n
  function automatic int main_mask_pos(int n);
    return (n < 16) ? (15 - n) : n;
  endfunction
endpackage

// File: rtl/irqe_prio_enc.sv
module irqe_prio_enc #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqe_dma_bank.sv
module irqe_dma_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] task_evt,
  input  logic         wr_pend,
  input  logic         wr_mask,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic         cascade_o
);
  logic [N-1:0] pend_q, mask_q, clr;

  assign clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= task_evt | (pend_q & ~clr);
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign pend_o    = pend_q;
  assign mask_o    = mask_q;
  assign cascade_o = |(pend_q & ~mask_q);
endmodule

// File: rtl/irq_status_encoder.sv
module irq_status_encoder
  import irqe_pkg::*;
#(
  parameter int CRIT_N = 4,
  parameter int MAIN_N = 17,
  parameter int PER_N  = 32,
  parameter int DMA_N  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRIT_N-1:0] crit_req,
  input  logic [MAIN_N-1:0] main_req,
  input  logic [PER_N-1:1]  per_req,
  input  logic [DMA_N-1:0]  dma_evt,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  status_word,
  output logic              cpu_irq
);
  localparam int CIW = $clog2(CRIT_N);
  localparam int MIW = $clog2(MAIN_N);
  localparam int PIW = $clog2(PER_N);

  logic [CRIT_N-1:0] crit_q;
  logic [MAIN_N-1:0] main_q, main_live;
  logic [PER_N-1:1]  per_q;
  logic [PER_N-1:0]  per_live;
  logic [REG_W-1:0]  main_mask_q, per_mask_q;
  logic [DMA_N-1:0]  dma_pend, dma_mask;
  logic              dma_cascade;
  logic              crit_hit, main_hit, per_hit;
  logic [CIW-1:0]    crit_idx;
  logic [MIW-1:0]    main_idx;
  logic [PIW-1:0]    per_idx;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q      <= '0;
      main_q      <= '0;
      per_q       <= '0;
      main_mask_q <= MAIN_MASK_INIT;
      per_mask_q  <= PER_MASK_INIT;
    end else begin
      crit_q <= crit_req;
      main_q <= main_req;
      per_q  <= per_req;
      if (reg_wr && addr == RA_MAIN_MASK) main_mask_q <= reg_wdata;
      if (reg_wr && addr == RA_PER_MASK)  per_mask_q  <= reg_wdata;
    end
  end

  irqe_dma_bank #(.N(DMA_N)) u_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .task_evt  (dma_evt),
    .wr_pend   (reg_wr && addr == RA_DMA_PEND),
    .wr_mask   (reg_wr && addr == RA_DMA_MASK),
    .wdata     (reg_wdata[DMA_N-1:0]),
    .pend_o    (dma_pend),
    .mask_o    (dma_mask),
    .cascade_o (dma_cascade)
  );

  for (genvar n = 0; n < MAIN_N; n++) begin : g_main
    localparam int MB = main_mask_pos(n);
    assign main_live[n] = main_q[n] & ~main_mask_q[MB];
  end

  for (genvar n = 0; n < PER_N; n++) begin : g_per
    if (n == 0) begin : g_cascade
      assign per_live[n] = dma_cascade & ~per_mask_q[REG_W-1];
    end else begin : g_plain
      assign per_live[n] = per_q[n] & ~per_mask_q[REG_W-1-n];
    end
  end

  irqe_prio_enc #(.W(CRIT_N)) u_crit (.req(crit_q),    .hit(crit_hit), .idx(crit_idx));
  irqe_prio_enc #(.W(MAIN_N)) u_main (.req(main_live), .hit(main_hit), .idx(main_idx));
  irqe_prio_enc #(.W(PER_N))  u_per  (.req(per_live),  .hit(per_hit),  .idx(per_idx));

  always_comb begin
    status_word = '0;
    status_word[CRIT_FLAG] = crit_hit;
    status_word[MAIN_FLAG] = main_hit;
    status_word[PER_FLAG]  = per_hit;
    if (crit_hit) status_word[CRIT_LSB +: CIW] = crit_idx;
    if (main_hit) status_word[MAIN_LSB +: MIW] = main_idx;
    if (per_hit)  status_word[PER_LSB  +: PIW] = per_idx;
  end

  assign cpu_irq = crit_hit | main_hit | per_hit;

  always_comb begin
    case (addr)
      RA_MAIN_MASK: reg_rdata = main_mask_q;
      RA_PER_MASK:  reg_rdata = per_mask_q;
      RA_DMA_PEND:  reg_rdata = REG_W'(dma_pend);
      default:      reg_rdata = REG_W'(dma_mask);
    endcase
  end
endmodule

// File: rtl/irqe_checks.sv
module irqe_checks #(
  parameter int CRIT_N = 4,
  parameter int DMA_N  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CRIT_N-1:0] crit_req,
  input logic [DMA_N-1:0]  dma_evt,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       status_word,
  input logic              cpu_irq,
  input logic [DMA_N-1:0]  dma_pend,
  input logic [DMA_N-1:0]  dma_mask,
  input logic [31:0]       per_mask
);
  // R2
  crit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|crit_req) |=> status_word[10]);

  // R2
  crit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_req == '0) |=> !status_word[10]);

  // R6
  dma_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_evt) |=> ((dma_pend & $past(dma_evt)) == $past(dma_evt)));

  // R6
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=>
      ((dma_pend & $past(reg_wdata[DMA_N-1:0] & ~dma_evt)) == '0));

  // R5
  cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dma_pend & ~dma_mask)) && !per_mask[31]) |->
      (status_word[29] && status_word[28:24] == 5'd0));

  // R7
  field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_word[10] || status_word[9:8] == 2'd0) &&
     (status_word[21] || status_word[20:16] == 5'd0) &&
     (status_word[29] || status_word[28:24] == 5'd0) &&
     (status_word & 32'hc0c0_f8ff) == 32'd0));

  // R8
  cpu_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (status_word[10] | status_word[21] | status_word[29]));
endmodule

bind irq_status_encoder irqe_checks #(.CRIT_N(CRIT_N), .DMA_N(DMA_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .crit_req    (crit_req),
  .dma_evt     (dma_evt),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .status_word (status_word),
  .cpu_irq     (cpu_irq),
  .dma_pend    (dma_pend),
  .dma_mask    (dma_mask),
  .per_mask    (per_mask_q)
);

// File: tb/sim_irq_status_encoder.sv
`timescale 1ns/1ps
module sim_irq_status_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [31:1] per_req = '0;
  logic [31:0] dma_evt = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, status_word;
  logic        cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_encoder u0 (
    .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
    .per_req(per_req), .dma_evt(dma_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_word(status_word),
    .cpu_irq(cpu_irq)
  );

  // behavioural reference state
  logic [3:0]  m_crit;
  logic [16:0] m_main;
  logic [31:1] m_per;
  logic [31:0] m_mmask, m_pmask, m_pend, m_dmask;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_crit <= '0; m_main <= '0; m_per <= '0;
      m_mmask <= 32'h0001_0fff; m_pmask <= 32'h7fff_fc00;
      m_pend <= '0; m_dmask <= 32'hffff_ffff;
    end else begin
      m_crit <= crit_req; m_main <= main_req; m_per <= per_req;
      if (reg_wr && reg_addr == 2'd0) m_mmask <= reg_wdata;
      if (reg_wr && reg_addr == 2'd1) m_pmask <= reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_dmask <= reg_wdata;
      for (int i = 0; i < 32; i++) begin
        if (dma_evt[i]) m_pend[i] <= 1'b1;
        else if (reg_wr && reg_addr == 2'd2 && reg_wdata[i]) m_pend[i] <= 1'b0;
      end
    end
  end

  function automatic logic [31:0] exp_status();
    logic [31:0] e = '0;
    for (int i = 0; i < 4; i++)
      if (m_crit[i]) begin e[10] = 1'b1; e[9:8] = i[1:0]; break; end
    for (int i = 0; i < 17; i++) begin
      int mb = (i < 16) ? 15 - i : 16;
      if (m_main[i] && !m_mmask[mb]) begin e[21] = 1'b1; e[20:16] = i[4:0]; break; end
    end
    for (int i = 0; i < 32; i++) begin
      bit live;
      if (i == 0) live = (|(m_pend & ~m_dmask)) && !m_pmask[31];
      else        live = m_per[i] && !m_pmask[31 - i];
      if (live) begin e[29] = 1'b1; e[28:24] = i[4:0]; break; end
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (reg_addr)
      2'd0: return m_mmask;
      2'd1: return m_pmask;
      2'd2: return m_pend;
      default: return m_dmask;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [31:0] e = exp_status();
    logic [31:0] r = exp_rdata();
    chk((status_word & 32'h0000_0700) == (e & 32'h0000_0700), "R2 critical field", status_word, e);
    chk((status_word & 32'h003f_0000) == (e & 32'h003f_0000), "R3 main field", status_word, e);
    chk((status_word & 32'h3f00_0000) == (e & 32'h3f00_0000), "R4 R5 peripheral field", status_word, e);
    chk((status_word & 32'hc0c0_f8ff) == 32'd0, "R7 unused bits", status_word, 32'd0);
    chk(cpu_irq == (e[10] | e[21] | e[29]), "R8 cpu_irq", {31'd0, cpu_irq}, {31'd0, e[10] | e[21] | e[29]});
    chk(reg_rdata == r, "R10 read data", reg_rdata, r);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk(status_word == 0 && cpu_irq == 0, "R1 status in reset", status_word, 0);
    rst_n = 1'b1;
    step();
    // R1: reset values of every register
    reg_addr = 2'd0; #1; chk(reg_rdata == 32'h0001_0fff, "R1 main mask", reg_rdata, 32'h0001_0fff);
    reg_addr = 2'd1; #1; chk(reg_rdata == 32'h7fff_fc00, "R1 peripheral mask", reg_rdata, 32'h7fff_fc00);
    reg_addr = 2'd2; #1; chk(reg_rdata == 32'h0, "R1 dma pending", reg_rdata, 32'h0);
    reg_addr = 2'd3; #1; chk(reg_rdata == 32'hffff_ffff, "R1 dma mask", reg_rdata, 32'hffff_ffff);
    chk(status_word == 0, "R1 status after reset", status_word, 0);

    // R2: lowest critical wins, one cycle latency
    crit_req = 4'b1010;
    #1; chk(status_word[10] == 1'b0, "R2 not yet visible", status_word, 0);
    step();
    chk(status_word[10:8] == 3'b101, "R2 lowest critical", status_word, 32'h500);
    crit_req = 4'b1000; step();
    chk(status_word[10:8] == 3'b111, "R2 critical 3", status_word, 32'h700);

    // R9: critical code 2 with a peripheral source alongside
    crit_req = 4'b0100; per_req = '0; per_req[25] = 1'b1; step();
    chk(status_word[10:8] == 3'b110 && status_word[29:24] == 6'h39, "R9 fields together",
        status_word, 32'h3900_0600);
    crit_req = '0; per_req = '0;

    // R3: default mask leaves main 0..3 live, hides 4..16
    main_req = 17'h1_0010; step();
    chk(status_word[21] == 1'b0, "R3 masked main", status_word, 0);
    wr(2'd0, 32'h0000_0000); step();
    chk(status_word[21:16] == 6'h24, "R3 main 4 unmasked", status_word, 32'h0024_0000);
    wr(2'd0, 32'h0000_0800); step();  // bit 11 disables main 4
    chk(status_word[21:16] == 6'h30, "R3 main 16 after reversed mask", status_word, 32'h0030_0000);
    main_req = '0;

    // R4: peripheral mask order
    per_req[3] = 1'b1; per_req[22] = 1'b1; step();
    chk(status_word[29:24] == 6'h36, "R4 default masks source 3", status_word, 32'h3600_0000);
    wr(2'd1, 32'h0000_0000); step();
    chk(status_word[29:24] == 6'h23, "R4 source 3 unmasked", status_word, 32'h2300_0000);
    per_req = '0;

    // R5, R6: DMA cascade
    wr(2'd3, ~32'h8);
    dma_evt = 32'h20; step(); dma_evt = '0; step();
    chk(status_word[29] == 1'b0, "R5 masked task no cascade", status_word, 0);
    per_req[9] = 1'b1;
    dma_evt = 32'h8; step(); dma_evt = '0; step();
    chk(status_word[29:24] == 6'h20, "R5 cascade as source 0", status_word, 32'h2000_0000);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 32'h28, "R6 sticky pending", reg_rdata, 32'h28);
    dma_evt = 32'h8; wr(2'd2, 32'h8); dma_evt = '0;
    reg_addr = 2'd2; #1;
    chk(reg_rdata[3] == 1'b1, "R6 set wins over clear", reg_rdata, 32'h28);
    wr(2'd2, 32'hffff_ffff);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 32'h0, "R6 write ones clears", reg_rdata, 0);
    chk(status_word[29:24] == 6'h29, "R5 cascade gone", status_word, 32'h2900_0000);
    per_req = '0;

    // random phase, compared every cycle
    for (int k = 0; k < 4000; k++) begin
      crit_req  = 4'($urandom() & $urandom() & $urandom());
      main_req  = 17'($urandom());
      per_req   = 31'($urandom() & $urandom());
      dma_evt   = $urandom() & $urandom() & $urandom() & $urandom();
      reg_wr    = ($urandom() % 4) == 0;
      reg_addr  = 2'($urandom());
      reg_wdata = $urandom();
      step();
    end
    reg_wr = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule